// File: doc/BRIEF.md
# Stereo Digital Volume and Level Monitor

This block sits in front of a stereo audio converter's interpolation filter. Several sample sources arrive at its input. Each source has a valid strobe and a pair of signed left and right samples. A source-select field in a control register picks which source is processed. Each channel then goes through its own logarithmic attenuator and its own mute. The block emits the processed pair together with a single output strobe.

Each channel also has a level monitor, which looks at the selected input before any attenuation. It keeps the largest magnitude seen since the last time software read it. It also raises a zero-data flag once the channel has carried a long run of silent samples. Software reaches every setting and both peak registers through a small register read/write port. The block leaves reset with both channels muted, so nothing reaches the converter until software has set it up.

Top module: `stereo_vol_path`

## Requirements
- R1: The source select sits in bits [4:2] of the control register (address 2), and a value below NUM_SRC routes that source's valid strobe and samples. When the select is NUM_SRC or above, the block produces no output strobe at all.
- R2: The 8-bit volume code v attenuates in steps of 1/16 of a factor of two (about 0.376 dB). The output is floor(x·G[v mod 16] / 2^(15 + v div 16) + 1/2), where G[k] = round(32768·2^(−k/16)). Code 0 passes the sample through unchanged.
- R3: The left volume lives at address 0 and the right volume at address 1. Each channel uses only its own volume code and its own mute bit.
- R4: Reset leaves both volumes at 0, the select at 0 and both mutes set, so the control register reads 3. Reset also clears both peaks, both zero flags and both outputs.
- R5: A muted channel (control bit 0 for left, bit 1 for right) outputs zero. Its output strobe still follows every selected input strobe.
- R6: The output strobe rises exactly two clock cycles after the selected input strobe is sampled. It stays low when no selected strobe was sampled.
- R7: A sample uses the volume and mute values held when its input strobe is sampled. A register write in that same cycle takes effect from the next strobe onward.
- R8: Each peak register (left at address 3, right at address 4) holds the largest input magnitude since it was last cleared. The magnitude is taken before attenuation and mute, and the most negative input counts as 2^23 − 1.
- R9: Reading a peak register returns its value and clears it to zero. If a selected strobe arrives in the same cycle as the read, the register holds that sample's magnitude afterwards.
- R10: A channel's zero flag (zero_flag bit 0 for left, bit 1 for right) goes high once 1024 consecutive selected samples on that channel have been zero. It drops after the first nonzero sample.
- R11: A read returns data on reg_rdata one cycle after reg_rd is sampled. Addresses 0 to 2 read back what was written, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_vld | input | NUM_SRC | Per-source sample strobe |
| src_l | input | NUM_SRC*DATA_W | Left samples, source i at bits [i*DATA_W +: DATA_W] |
| src_r | input | NUM_SRC*DATA_W | Right samples, same packing |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid the cycle after reg_rd |
| out_vld | output | 1 | Processed sample strobe |
| out_l | output | DATA_W | Processed left sample |
| out_r | output | DATA_W | Processed right sample |
| zero_flag | output | 2 | Zero-data flags, bit 0 left, bit 1 right |

## Verification
The bench sweeps all 256 volume codes on both channels at once, running the two channels in opposite directions. It uses full-scale, smallest-magnitude and mixed-sign samples. A wrong gain entry, an off-by-one shift, or rounding toward zero instead of half-up shows up as a one-LSB error on negative values. The bench writes a register in the very cycle of a strobe, so a design that applies settings as soon as they are written processes that sample with the new setting. Further checks cover a peak read that coincides with a new sample, the most negative input, the 1023rd versus the 1024th zero sample, and select values above the source count. These catch a design that loses the new peak, reports a negative magnitude, flags one sample early, or wraps the select onto a real source.

// File: rtl/svp_pkg.sv
package svp_pkg;
   localparam int VOL_W   = 8;
   localparam int FRAC_W  = 4;
   localparam int GAIN_W  = 16;
   localparam int GAIN_FB = 15;
   localparam int SEL_W   = 3;

   localparam logic [2:0] A_VOL_L  = 3'd0;
   localparam logic [2:0] A_VOL_R  = 3'd1;
   localparam logic [2:0] A_CTRL   = 3'd2;
   localparam logic [2:0] A_PEAK_L = 3'd3;
   localparam logic [2:0] A_PEAK_R = 3'd4;

   typedef struct packed {
      logic [SEL_W-1:0] src;
      logic             mute_r;
      logic             mute_l;
   } ctrl_t;

   // Gain for the fractional part of the volume code, 2^(-k/16) in Q1.15
   function automatic logic [GAIN_W-1:0] frac_gain(input logic [FRAC_W-1:0] k);
      case (k)
         4'd0:  frac_gain = 16'd32768;
         4'd1:  frac_gain = 16'd31379;
         4'd2:  frac_gain = 16'd30048;
         4'd3:  frac_gain = 16'd28774;
         4'd4:  frac_gain = 16'd27554;
         4'd5:  frac_gain = 16'd26386;
         4'd6:  frac_gain = 16'd25268;
         4'd7:  frac_gain = 16'd24196;
         4'd8:  frac_gain = 16'd23170;
         4'd9:  frac_gain = 16'd22188;
         4'd10: frac_gain = 16'd21247;
         4'd11: frac_gain = 16'd20347;
         4'd12: frac_gain = 16'd19484;
         4'd13: frac_gain = 16'd18658;
         4'd14: frac_gain = 16'd17867;
         4'd15: frac_gain = 16'd17109;
      endcase
   endfunction
endpackage

// File: rtl/svp_src_mux.sv
module svp_src_mux #(
   parameter int DATA_W  = 24,
   parameter int NUM_SRC = 5,
   parameter int SEL_W   = 3
) (
   input  logic [NUM_SRC-1:0]        vld_i,
   input  logic [NUM_SRC*DATA_W-1:0] l_i,
   input  logic [NUM_SRC*DATA_W-1:0] r_i,
   input  logic [SEL_W-1:0]          sel_i,
   output logic                      vld_o,
   output logic [DATA_W-1:0]         l_o,
   output logic [DATA_W-1:0]         r_o
);
   logic [NUM_SRC-1:0] hit;
   logic [DATA_W-1:0]  l_m [NUM_SRC];
   logic [DATA_W-1:0]  r_m [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = (sel_i == SEL_W'(i));
      assign l_m[i] = l_i[i*DATA_W +: DATA_W] & {DATA_W{hit[i]}};
      assign r_m[i] = r_i[i*DATA_W +: DATA_W] & {DATA_W{hit[i]}};
   end

   always_comb begin
      l_o = '0;
      r_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         l_o = l_o | l_m[i];
         r_o = r_o | r_m[i];
      end
   end

   assign vld_o = |(vld_i & hit);
endmodule

// File: rtl/svp_chan_gain.sv
module svp_chan_gain
   import svp_pkg::*;
#(
   parameter int DATA_W = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic signed [DATA_W-1:0] smp_i,
   input  logic [VOL_W-1:0]         att_i,
   input  logic                     mute_i,
   output logic signed [DATA_W-1:0] smp_o
);
   localparam int PW = DATA_W + GAIN_W + 1;
   localparam logic signed [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

   logic signed [PW-1:0]     smp_x, gain_x, prod, rnd, acc, scaled;
   logic [5:0]               sh;
   logic                     fits;
   logic signed [DATA_W-1:0] res;

   assign smp_x  = PW'(smp_i);
   assign gain_x = PW'(frac_gain(att_i[FRAC_W-1:0]));
   assign prod   = smp_x * gain_x;
   assign sh     = 6'(GAIN_FB) + 6'(att_i[VOL_W-1:FRAC_W]);
   assign rnd    = {{(PW-1){1'b0}}, 1'b1} << (sh - 6'd1);
   assign acc    = prod + rnd;
   assign scaled = acc >>> sh;
   assign fits   = (scaled[PW-1:DATA_W-1] == '0) || (scaled[PW-1:DATA_W-1] == '1);

   always_comb begin
      if (fits)               res = scaled[DATA_W-1:0];
      else if (scaled[PW-1])  res = SMIN;
      else                    res = SMAX;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     smp_o <= '0;
      else if (vld_i) smp_o <= mute_i ? '0 : res;
   end

   // R5
   mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i && mute_i |=> smp_o == '0);
   // R2
   unity_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i && !mute_i && att_i == '0 |=> smp_o == $past(smp_i));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> $stable(smp_o));
endmodule

// File: rtl/svp_lvl_mon.sv
module svp_lvl_mon #(
   parameter int DATA_W   = 24,
   parameter int ZERO_RUN = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     stb_i,
   input  logic signed [DATA_W-1:0] smp_i,
   input  logic                     clr_i,
   output logic [DATA_W-1:0]        peak_o,
   output logic                     zero_o
);
   localparam int CNT_W = $clog2(ZERO_RUN + 1);
   localparam logic [CNT_W-1:0] RUN_END = CNT_W'(ZERO_RUN);
   localparam logic signed [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] mag;
   logic [CNT_W-1:0]  run_q;

   always_comb begin
      if (!smp_i[DATA_W-1])  mag = smp_i;
      else if (smp_i == SMIN) mag = SMAX;
      else                   mag = -smp_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     peak_o <= '0;
      else if (clr_i)                 peak_o <= stb_i ? mag : '0;
      else if (stb_i && mag > peak_o) peak_o <= mag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= '0;
      else if (stb_i) begin
         if (smp_i != '0)           run_q <= '0;
         else if (run_q != RUN_END) run_q <= run_q + 1'b1;
      end
   end

   assign zero_o = (run_q == RUN_END);

   // R9
   peak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !stb_i |=> peak_o == '0);
   // R8
   peak_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> peak_o >= $past(peak_o));
   // R8
   peak_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i |=> peak_o >= $past(mag));
   // R10
   zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i && smp_i != '0 |=> !zero_o);
endmodule

// File: rtl/stereo_vol_path.sv
module stereo_vol_path
   import svp_pkg::*;
#(
   parameter int DATA_W   = 24,
   parameter int NUM_SRC  = 5,
   parameter int ZERO_RUN = 1024
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        src_vld,
   input  logic [NUM_SRC*DATA_W-1:0] src_l,
   input  logic [NUM_SRC*DATA_W-1:0] src_r,
   input  logic                      reg_wr,
   input  logic                      reg_rd,
   input  logic [2:0]                reg_addr,
   input  logic [7:0]                reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   output logic                      out_vld,
   output logic [DATA_W-1:0]         out_l,
   output logic [DATA_W-1:0]         out_r,
   output logic [1:0]                zero_flag
);
   localparam int NUM_CH = 2;

   if (NUM_SRC < 2 || NUM_SRC > (1 << SEL_W)) begin : g_bad_src
      $error("NUM_SRC must fit the select field");
   end
   if (DATA_W < 16 || DATA_W > 32) begin : g_bad_width
      $error("DATA_W out of supported range");
   end
   if (ZERO_RUN < 1) begin : g_bad_run
      $error("ZERO_RUN must be positive");
   end

   logic [NUM_CH-1:0][VOL_W-1:0]  vol_q;
   ctrl_t                         ctrl_q;
   logic [NUM_CH-1:0]             mute_v;
   logic                          mux_vld;
   logic [NUM_CH-1:0][DATA_W-1:0] mux_smp;
   logic                          s1_vld;
   logic [NUM_CH-1:0][DATA_W-1:0] s1_smp;
   logic [NUM_CH-1:0][VOL_W-1:0]  s1_att;
   logic [NUM_CH-1:0]             s1_mute;
   logic [NUM_CH-1:0][DATA_W-1:0] peak_v;
   logic [NUM_CH-1:0][DATA_W-1:0] out_v;
   logic [NUM_CH-1:0]             clr_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vol_q  <= '0;
         ctrl_q <= '{src: '0, mute_r: 1'b1, mute_l: 1'b1};
      end else if (reg_wr) begin
         case (reg_addr)
            A_VOL_L: vol_q[0] <= reg_wdata;
            A_VOL_R: vol_q[1] <= reg_wdata;
            A_CTRL:  ctrl_q   <= ctrl_t'(reg_wdata[SEL_W+1:0]);
            default: ;
         endcase
      end
   end

   assign mute_v = {ctrl_q.mute_r, ctrl_q.mute_l};

   svp_src_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .vld_i (src_vld),
      .l_i   (src_l),
      .r_i   (src_r),
      .sel_i (ctrl_q.src),
      .vld_o (mux_vld),
      .l_o   (mux_smp[0]),
      .r_o   (mux_smp[1])
   );

   // snapshot of sample and settings at the strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_smp  <= '0;
         s1_att  <= '0;
         s1_mute <= '1;
      end else begin
         s1_vld <= mux_vld;
         if (mux_vld) begin
            s1_smp  <= mux_smp;
            s1_att  <= vol_q;
            s1_mute <= mute_v;
         end
      end
   end

   assign clr_v[0] = reg_rd && (reg_addr == A_PEAK_L);
   assign clr_v[1] = reg_rd && (reg_addr == A_PEAK_R);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      svp_chan_gain #(.DATA_W(DATA_W)) u_gain (
         .clk    (clk),
         .rst_n  (rst_n),
         .vld_i  (s1_vld),
         .smp_i  ($signed(s1_smp[ch])),
         .att_i  (s1_att[ch]),
         .mute_i (s1_mute[ch]),
         .smp_o  (out_v[ch])
      );
      svp_lvl_mon #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_mon (
         .clk    (clk),
         .rst_n  (rst_n),
         .stb_i  (mux_vld),
         .smp_i  ($signed(mux_smp[ch])),
         .clr_i  (clr_v[ch]),
         .peak_o (peak_v[ch]),
         .zero_o (zero_flag[ch])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= s1_vld;
   end

   assign out_l = out_v[0];
   assign out_r = out_v[1];

   always_ff @(posedge clk) begin
      if (!rst_n) reg_rdata <= '0;
      else if (reg_rd) begin
         case (reg_addr)
            A_VOL_L:  reg_rdata <= DATA_W'(vol_q[0]);
            A_VOL_R:  reg_rdata <= DATA_W'(vol_q[1]);
            A_CTRL:   reg_rdata <= DATA_W'(ctrl_q);
            A_PEAK_L: reg_rdata <= peak_v[0];
            A_PEAK_R: reg_rdata <= peak_v[1];
            default:  reg_rdata <= '0;
         endcase
      end
   end

   // R6
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld |=> out_vld);
   // R6
   no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_vld |=> !out_vld);
   // R1
   sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ctrl_q.src) >= NUM_SRC |-> !mux_vld);
endmodule

// File: tb/stereo_vol_path_tb.sv
module stereo_vol_path_tb_top;
   localparam int DW = 24;
   localparam int NS = 5;
   localparam int ZR = 1024;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NS-1:0]   src_vld;
   logic [NS*DW-1:0] src_l, src_r;
   logic            reg_wr, reg_rd;
   logic [2:0]      reg_addr;
   logic [7:0]      reg_wdata;
   logic [DW-1:0]   reg_rdata;
   logic            out_vld;
   logic [DW-1:0]   out_l, out_r;
   logic [1:0]      zero_flag;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;
   int  cur_sel = 0;

   always #10 clk = ~clk;

   stereo_vol_path #(.DATA_W(DW), .NUM_SRC(NS), .ZERO_RUN(ZR)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_l(src_l), .src_r(src_r),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .out_vld(out_vld), .out_l(out_l), .out_r(out_r),
      .zero_flag(zero_flag)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint gtab(input int k);
      return longint'($floor(32768.0 * (2.0 ** (-real'(k) / 16.0)) + 0.5));
   endfunction

   function automatic longint expv(input longint x, input int v, input bit m);
      longint p;
      int     s;
      if (m) return 0;
      s = 15 + v / 16;
      p = x * gtab(v % 16);
      return (p + (longint'(1) <<< (s - 1))) >>> s;
   endfunction

   task automatic drive_src(input int l, input int r);
      for (int i = 0; i < NS; i++) begin
         if (i == cur_sel) begin
            src_l[i*DW +: DW] = l[DW-1:0];
            src_r[i*DW +: DW] = r[DW-1:0];
         end else begin
            src_l[i*DW +: DW] = l[DW-1:0] ^ 24'h5A5A5A ^ DW'(i + 1);
            src_r[i*DW +: DW] = r[DW-1:0] ^ 24'hA5A5A5 ^ DW'(i + 3);
         end
         src_vld[i] = 1'b1;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output longint d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = longint'(reg_rdata);
   endtask

   task automatic push(input int l, input int r, output longint ol, output longint orr, output bit ov);
      @(negedge clk);
      drive_src(l, r);
      @(negedge clk);
      src_vld = '0;
      @(negedge clk);
      ov  = out_vld;
      ol  = longint'($signed(out_l));
      orr = longint'($signed(out_r));
   endtask

   task automatic fast_push(input int l, input int r);
      @(negedge clk);
      drive_src(l, r);
      @(negedge clk);
      src_vld = '0;
   endtask

   initial begin : wd
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all): actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      longint ol, orr, d;
      bit     ov;
      int     samp [6] = '{8388607, -8388608, 12345, -777777, 1, -1};

      rst_n = 1'b0; src_vld = '0; src_l = '0; src_r = '0;
      reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (4) @(negedge clk);
      // R4 outputs during reset
      chk("R4 out_vld", longint'(out_vld), 0);
      chk("R4 out_l", longint'(out_l), 0);
      chk("R4 zero_flag", longint'(zero_flag), 0);
      rst_n = 1'b1;

      // R4 register state after reset
      rd(3'd0, d); chk("R4 vol_l", d, 0);
      rd(3'd1, d); chk("R4 vol_r", d, 0);
      rd(3'd2, d); chk("R4 ctrl", d, 3);
      rd(3'd3, d); chk("R4 peak_l", d, 0);
      rd(3'd4, d); chk("R4 peak_r", d, 0);

      // R5 muted out of reset, strobe still follows
      push(1000, -1000, ol, orr, ov);
      chk("R5 vld", longint'(ov), 1);
      chk("R5 l", ol, 0);
      chk("R5 r", orr, 0);
      // R8 peak measured before mute; R9 read clears
      rd(3'd3, d); chk("R8 peak_l", d, 1000);
      rd(3'd3, d); chk("R9 cleared", d, 0);

      // R11 readback and unmapped address
      wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h09);
      rd(3'd0, d); chk("R11 vol_l", d, 'hA5);
      rd(3'd1, d); chk("R11 vol_r", d, 'h3C);
      rd(3'd2, d); chk("R11 ctrl", d, 'h09);
      rd(3'd6, d); chk("R11 unmapped", d, 0);
      wr(3'd2, 8'h00);

      // R6 latency
      @(negedge clk); drive_src(77, 88);
      @(negedge clk); src_vld = '0; chk("R6 early", longint'(out_vld), 0);
      @(negedge clk); chk("R6 on time", longint'(out_vld), 1);
      @(negedge clk); chk("R6 single", longint'(out_vld), 0);

      // R2 / R3 full volume sweep, channels in opposite directions
      for (int v = 0; v < 256; v++) begin
         wr(3'd0, 8'(v));
         wr(3'd1, 8'(255 - v));
         for (int j = 0; j < 6; j++) begin
            push(samp[j], samp[(j + 1) % 6], ol, orr, ov);
            chk("R2 left", ol, expv(samp[j], v, 0));
            chk("R3 right", orr, expv(samp[(j + 1) % 6], 255 - v, 0));
         end
      end

      // R5 per-channel mute (right only)
      wr(3'd0, 8'd0); wr(3'd1, 8'd0); wr(3'd2, 8'h02);
      push(4321, 4321, ol, orr, ov);
      chk("R5 left open", ol, 4321);
      chk("R5 right muted", orr, 0);
      wr(3'd2, 8'h00);

      // R1 source selection, including out-of-range values
      for (int s = 0; s < 8; s++) begin
         wr(3'd2, 8'(s << 2));
         cur_sel = s;
         push(1000 + s * 11, -2000 - s, ol, orr, ov);
         if (s < NS) begin
            chk("R1 vld", longint'(ov), 1);
            chk("R1 left", ol, 1000 + s * 11);
            chk("R1 right", orr, -2000 - s);
         end else begin
            chk("R1 no output", longint'(ov), 0);
         end
      end
      cur_sel = 0;
      wr(3'd2, 8'h00);

      // R7 write in the strobe cycle applies from the next sample
      @(negedge clk);
      drive_src(300000, -300000);
      reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'd64;
      @(negedge clk); src_vld = '0; reg_wr = 1'b0;
      @(negedge clk); chk("R7 old volume", longint'($signed(out_l)), 300000);
      push(300000, -300000, ol, orr, ov);
      chk("R7 new volume", ol, expv(300000, 64, 0));
      @(negedge clk);
      drive_src(300000, -300000);
      reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h03;
      @(negedge clk); src_vld = '0; reg_wr = 1'b0;
      @(negedge clk); chk("R7 old mute", longint'($signed(out_r)), -300000);
      push(300000, -300000, ol, orr, ov);
      chk("R7 new mute", orr, 0);

      // R8 magnitude before attenuation, most negative saturates
      wr(3'd0, 8'd255); wr(3'd1, 8'd255);
      rd(3'd3, d); rd(3'd4, d);
      push(-8388608, 5, ol, orr, ov);
      rd(3'd3, d); chk("R8 min neg", d, 8388607);
      rd(3'd4, d); chk("R8 small", d, 5);
      push(100, -200, ol, orr, ov);
      push(50, -300, ol, orr, ov);
      rd(3'd3, d); chk("R8 max l", d, 100);
      rd(3'd4, d); chk("R8 max r", d, 300);

      // R9 read-clear coinciding with a new sample
      push(4000, 0, ol, orr, ov);
      @(negedge clk);
      drive_src(123, 0);
      reg_rd = 1'b1; reg_addr = 3'd3;
      @(negedge clk); src_vld = '0; reg_rd = 1'b0;
      chk("R9 old value", longint'(reg_rdata), 4000);
      rd(3'd3, d); chk("R9 new sample kept", d, 123);

      // R10 zero run on left only
      for (int k = 0; k < ZR - 1; k++) fast_push(0, 7);
      @(negedge clk); chk("R10 before run", longint'(zero_flag), 0);
      fast_push(0, 7);
      @(negedge clk); chk("R10 at run", longint'(zero_flag), 1);
      fast_push(0, 7);
      @(negedge clk); chk("R10 held", longint'(zero_flag), 1);
      fast_push(5, 7);
      @(negedge clk); chk("R10 drop", longint'(zero_flag), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule